// File: doc/BRIEF.md
# Peripheral Bus Access Permission Checker

This block sits in front of an on-chip peripheral bus and judges every access before it reaches a target. Each access arrives with an address offset from the peripheral base, a privilege flag (supervisor or user), a direction flag and a flag that marks instruction fetches. In the same cycle the block raises either `acc_allow`, which lets the access continue, or `acc_err`, which ends the bus cycle at once with an error.

Permissions are held at two levels. The peripheral space is split into sixteen 64-Mbyte regions, and the first two regions each have a coarse 8-bit region register. A set of fine-grained 4-bit module fields covers individual module windows inside region 0. When an address falls in a module window, only that module's field counts and the region register is not consulted. Fetch rights are judged apart from read and write rights, and no module window ever grants a fetch.

Software programs the permission registers through a byte-wide configuration port that offers write and combinational read-back. Every register and module field has a lock bit. Once the lock is set, the register or field stays fixed until reset.

Top module: `pac_access_checker`

## Requirements
- R1: Address bits [29:26] select the region. Regions 0 and 1 use region registers 0 and 1. For any access to regions 2 to 15, `acc_err` is high and `acc_allow` is low.
- R2: When `acc_valid` is high, exactly one of `acc_allow` and `acc_err` is high, in the same cycle and with no register delay. When `acc_valid` is low, both are low.
- R3: The low three bits of a region code decide reads and writes. 0 gives supervisor read/write and no user access. 1 gives supervisor read only. 2 gives read/write in both modes. 3 gives supervisor read/write and user read only. Codes 4 to 7 deny everything. Bit 3 does not change these read/write rights.
- R4: A fetch to a region is allowed only for codes 8 to 11, and only when the mode has read rights under the low three bits. Every other fetch returns an error.
- R5: Module k (k from 0 to 15) owns the offsets for which address bits [29:16] equal k+1. For such an access, only the module field decides the result. Bits [29:16] equal to 0 or above 16 fall back to the region register.
- R6: A module field is a nibble: bit 3 is its lock and bits 2:0 are a code that uses the R3 meanings. Any fetch to a module window returns an error.
- R7: After reset, all region registers read 0x00 and all module fields read 0. This means supervisor read/write only, with no user access and no fetch.
- R8: The region registers are at configuration offsets 0x30 and 0x31, laid out as bit 7 lock, bits 6:4 always read 0, and bits 3:0 code. The module bytes are at offsets 0x24 to 0x2B. Module 2n is in the high nibble of byte 0x24+n and module 2n+1 is in the low nibble. Unmapped offsets read 0.
- R9: Once a lock bit reads 1, later writes leave that register, or that module nibble, unchanged until reset. A write to a byte only updates the unlocked nibble of that byte.
- R10: `cfg_err` is high in the cycle of a write that is made in user mode or that targets an unmapped offset. Such a write changes nothing. Supervisor writes to mapped offsets never raise `cfg_err`, locked or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Bus access present this cycle |
| acc_addr | input | 30 | Byte offset from the peripheral base |
| acc_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_allow | output | 1 | Access may proceed |
| acc_err | output | 1 | Terminate access with error |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_super | input | 1 | Privilege of the configuration access |
| cfg_rdata | output | 8 | Combinational read-back of the addressed register |
| cfg_err | output | 1 | Configuration write refused |

## Verification
The assertions check these rules on every cycle:
- Allow and error are mutually exclusive, and exactly one of them answers each valid access.
- Reserved regions and fetches into module windows always fail.
- A user-mode configuration write always flags an error and changes no register.
- A register that reads back as locked never changes.

The rules that need the programmed state can only be shown by the bench's scenarios. These are the meaning of each code for every mode and direction, module fields taking precedence over region registers, the window boundaries, the nibble packing, and reset values. The bench shows them by comparing every cycle against its behavioural model, through directed sweeps and a randomized phase.

// File: rtl/pac_pkg.sv
package pac_pkg;

    // Read/write right for a 3-bit permission code.
    function automatic logic perm_rw_ok(input logic [2:0] code,
                                        input logic sup,
                                        input logic wr);
        logic ok;
        case (code)
            3'd0:    ok = sup;
            3'd1:    ok = sup & ~wr;
            3'd2:    ok = 1'b1;
            3'd3:    ok = sup | ~wr;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pac_perm_eval.sv
module pac_perm_eval
    import pac_pkg::*;
(
    input  logic [3:0] code,
    input  logic       is_module,
    input  logic       sup,
    input  logic       wr,
    input  logic       fetch,
    output logic       ok
);
    logic rd_right;
    logic rw_right;

    always_comb begin
        rd_right = perm_rw_ok(code[2:0], sup, 1'b0);
        rw_right = perm_rw_ok(code[2:0], sup, wr);
        if (fetch) begin
            // module windows never execute; regions need the execute bit
            ok = ~is_module & code[3] & rd_right;
        end else begin
            ok = rw_right;
        end
    end
endmodule

// File: rtl/pac_regfile.sv
module pac_regfile #(
    parameter int NUM_GRP = 2,
    parameter int NUM_MOD = 16,
    parameter int CFG_AW  = 8,
    parameter int GRP_OFS = 'h30,
    parameter int MOD_OFS = 'h24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_wr,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [7:0]                  cfg_wdata,
    input  logic                        cfg_super,
    output logic [7:0]                  cfg_rdata,
    output logic                        cfg_err,
    output logic [NUM_GRP-1:0][3:0]     grp_code,
    output logic [NUM_MOD-1:0][2:0]     mod_code
);
    localparam int MOD_BYTES = NUM_MOD / 2;

    typedef struct packed {
        logic [NUM_GRP-1:0]       g_lock;
        logic [NUM_GRP-1:0][3:0]  g_code;
        logic [NUM_MOD-1:0]       m_lock;
        logic [NUM_MOD-1:0][2:0]  m_code;
    } perm_state_t;

    perm_state_t st_d, st_q;
    logic        wr_ok;
    logic        hit;

    always_comb begin
        st_d      = st_q;
        cfg_rdata = '0;
        hit       = 1'b0;
        wr_ok     = cfg_wr & cfg_super;

        for (int g = 0; g < NUM_GRP; g++) begin
            if (cfg_addr == CFG_AW'(GRP_OFS + g)) begin
                hit       = 1'b1;
                cfg_rdata = {st_q.g_lock[g], 3'b000, st_q.g_code[g]};
                if (wr_ok && !st_q.g_lock[g]) begin
                    st_d.g_lock[g] = cfg_wdata[7];
                    st_d.g_code[g] = cfg_wdata[3:0];
                end
            end
        end

        for (int b = 0; b < MOD_BYTES; b++) begin
            if (cfg_addr == CFG_AW'(MOD_OFS + b)) begin
                hit       = 1'b1;
                cfg_rdata = {st_q.m_lock[2*b],   st_q.m_code[2*b],
                             st_q.m_lock[2*b+1], st_q.m_code[2*b+1]};
                if (wr_ok && !st_q.m_lock[2*b]) begin
                    st_d.m_lock[2*b] = cfg_wdata[7];
                    st_d.m_code[2*b] = cfg_wdata[6:4];
                end
                if (wr_ok && !st_q.m_lock[2*b+1]) begin
                    st_d.m_lock[2*b+1] = cfg_wdata[3];
                    st_d.m_code[2*b+1] = cfg_wdata[2:0];
                end
            end
        end

        cfg_err = cfg_wr & (~cfg_super | ~hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grp_code = st_q.g_code;
    assign mod_code = st_q.m_code;
endmodule

// File: rtl/pac_access_checker.sv
module pac_access_checker #(
    parameter int ADDR_W    = 30,
    parameter int NUM_GRP   = 2,
    parameter int NUM_MOD   = 16,
    parameter int MOD_SHIFT = 16,
    parameter int CFG_AW    = 8,
    parameter int GRP_OFS   = 'h30,
    parameter int MOD_OFS   = 'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_super,
    input  logic              acc_write,
    input  logic              acc_fetch,
    output logic              acc_allow,
    output logic              acc_err,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_super,
    output logic [7:0]        cfg_rdata,
    output logic              cfg_err
);
    localparam int UPW = ADDR_W - MOD_SHIFT;

    logic [NUM_GRP-1:0][3:0] grp_code;
    logic [NUM_MOD-1:0][2:0] mod_code;
    logic [3:0]              region;
    logic [UPW-1:0]          mod_sel;
    logic                    mod_hit;
    logic                    grp_hit;
    logic [3:0]              sel_code;
    logic                    code_ok;

    pac_regfile #(
        .NUM_GRP (NUM_GRP),
        .NUM_MOD (NUM_MOD),
        .CFG_AW  (CFG_AW),
        .GRP_OFS (GRP_OFS),
        .MOD_OFS (MOD_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_super (cfg_super),
        .cfg_rdata (cfg_rdata),
        .cfg_err   (cfg_err),
        .grp_code  (grp_code),
        .mod_code  (mod_code)
    );

    assign region  = acc_addr[ADDR_W-1 -: 4];
    assign mod_sel = acc_addr[ADDR_W-1:MOD_SHIFT];
    assign mod_hit = (mod_sel != '0) && (mod_sel <= UPW'(NUM_MOD));

    // Module field overrides the enclosing region register.
    always_comb begin
        sel_code = '0;
        grp_hit  = 1'b0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (region == 4'(g)) begin
                grp_hit  = 1'b1;
                sel_code = grp_code[g];
            end
        end
        if (mod_hit) begin
            for (int m = 0; m < NUM_MOD; m++) begin
                if (mod_sel == UPW'(m + 1)) begin
                    sel_code = {1'b0, mod_code[m]};
                end
            end
        end
    end

    pac_perm_eval u_eval (
        .code      (sel_code),
        .is_module (mod_hit),
        .sup       (acc_super),
        .wr        (acc_write),
        .fetch     (acc_fetch),
        .ok        (code_ok)
    );

    assign acc_allow = acc_valid & (grp_hit | mod_hit) & code_ok;
    assign acc_err   = acc_valid & ~((grp_hit | mod_hit) & code_ok);
endmodule

// File: rtl/pac_access_checker_sva.sv
module pac_access_checker_sva #(
    parameter int ADDR_W    = 30,
    parameter int NUM_GRP   = 2,
    parameter int NUM_MOD   = 16,
    parameter int MOD_SHIFT = 16,
    parameter int CFG_AW    = 8,
    parameter int GRP_OFS   = 'h30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_fetch,
    input logic              acc_allow,
    input logic              acc_err,
    input logic              cfg_wr,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic              cfg_super,
    input logic [7:0]        cfg_rdata,
    input logic              cfg_err
);
    localparam int UPW = ADDR_W - MOD_SHIFT;

    logic [3:0]     reg_idx;
    logic [UPW-1:0] win;
    logic           in_module;
    logic           at_group;

    assign reg_idx   = acc_addr[ADDR_W-1 -: 4];
    assign win       = acc_addr[ADDR_W-1:MOD_SHIFT];
    assign in_module = (win != '0) && (win <= UPW'(NUM_MOD));
    assign at_group  = (cfg_addr >= CFG_AW'(GRP_OFS)) &&
                       (cfg_addr <  CFG_AW'(GRP_OFS + NUM_GRP));

    p_one_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $onehot({acc_allow, acc_err}));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!acc_allow && !acc_err));

    p_reserved_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && reg_idx >= 4'(NUM_GRP)) |-> (acc_err && !acc_allow));

    p_module_no_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_fetch && in_module) |-> acc_err);

    p_user_cfg_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_super) |-> cfg_err);

    p_user_cfg_nochange_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_super) |=>
            (cfg_addr != $past(cfg_addr) || cfg_rdata == $past(cfg_rdata)));

    p_lock_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (at_group && cfg_rdata[7]) |=>
            (cfg_addr != $past(cfg_addr) || cfg_rdata == $past(cfg_rdata)));

    p_rsvd_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        at_group |-> (cfg_rdata[6:4] == 3'b000));
endmodule

bind pac_access_checker pac_access_checker_sva #(
    .ADDR_W    (ADDR_W),
    .NUM_GRP   (NUM_GRP),
    .NUM_MOD   (NUM_MOD),
    .MOD_SHIFT (MOD_SHIFT),
    .CFG_AW    (CFG_AW),
    .GRP_OFS   (GRP_OFS)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_fetch (acc_fetch),
    .acc_allow (acc_allow),
    .acc_err   (acc_err),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_super (cfg_super),
    .cfg_rdata (cfg_rdata),
    .cfg_err   (cfg_err)
);

// File: tb/pac_access_checker_tb.sv
module pac_access_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [29:0] acc_addr = '0;
    logic        acc_super = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_fetch = 1'b0;
    logic        acc_allow;
    logic        acc_err;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_super = 1'b0;
    logic [7:0]  cfg_rdata;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    bit       g_lock_m [2];
    int       g_code_m [2];
    bit       m_lock_m [16];
    int       m_code_m [16];

    always #2 clk = ~clk;

    pac_access_checker dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_super(acc_super),
        .acc_write(acc_write), .acc_fetch(acc_fetch),
        .acc_allow(acc_allow), .acc_err(acc_err),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_super(cfg_super), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err)
    );

    function automatic bit rights(int c, bit sup, bit wr);
        if (sup) return wr ? (c == 0 || c == 2 || c == 3) : (c >= 0 && c <= 3);
        return wr ? (c == 2) : (c == 2 || c == 3);
    endfunction

    function automatic bit model_ok(logic [29:0] a, bit sup, bit wr, bit fe);
        int reg_i = int'(a[29:26]);
        int win   = int'(a[29:16]);
        int c;
        if (reg_i > 1) return 0;
        if (win >= 1 && win <= 16) begin
            if (fe) return 0;
            return rights(m_code_m[win-1], sup, wr);
        end
        c = g_code_m[reg_i];
        if (fe) return (c >= 8 && c <= 11) && rights(c - 8, sup, 0);
        return rights(c % 8, sup, wr);
    endfunction

    function automatic logic [7:0] model_rd(logic [7:0] ad);
        int k;
        if (ad == 8'h30 || ad == 8'h31) begin
            k = int'(ad) - 'h30;
            return {g_lock_m[k], 3'b000, 4'(g_code_m[k])};
        end
        if (ad >= 8'h24 && ad <= 8'h2B) begin
            k = 2 * (int'(ad) - 'h24);
            return {m_lock_m[k], 3'(m_code_m[k]), m_lock_m[k+1], 3'(m_code_m[k+1])};
        end
        return 8'h00;
    endfunction

    function automatic bit mapped(logic [7:0] ad);
        return (ad == 8'h30 || ad == 8'h31 || (ad >= 8'h24 && ad <= 8'h2B));
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin g_lock_m[i] = 0; g_code_m[i] = 0; end
        for (int i = 0; i < 16; i++) begin m_lock_m[i] = 0; m_code_m[i] = 0; end
    endtask

    task automatic model_write(logic [7:0] ad, logic [7:0] d);
        int k;
        if (ad == 8'h30 || ad == 8'h31) begin
            k = int'(ad) - 'h30;
            if (!g_lock_m[k]) begin g_lock_m[k] = d[7]; g_code_m[k] = int'(d[3:0]); end
        end else if (ad >= 8'h24 && ad <= 8'h2B) begin
            k = 2 * (int'(ad) - 'h24);
            if (!m_lock_m[k])   begin m_lock_m[k]   = d[7]; m_code_m[k]   = int'(d[6:4]); end
            if (!m_lock_m[k+1]) begin m_lock_m[k+1] = d[3]; m_code_m[k+1] = int'(d[2:0]); end
        end
    endtask

    // One cycle: drive at negedge, compare mid-cycle, commit model at posedge.
    task automatic step(bit v, logic [29:0] a, bit sup, bit wr, bit fe,
                        bit cw, logic [7:0] ca, logic [7:0] wd, bit cs, string req);
        bit         e_allow, e_err, e_cerr;
        logic [7:0] e_rd;
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_super = sup; acc_write = wr; acc_fetch = fe;
        cfg_wr = cw; cfg_addr = ca; cfg_wdata = wd; cfg_super = cs;
        #1;
        e_allow = v && model_ok(a, sup, wr, fe);
        e_err   = v && !model_ok(a, sup, wr, fe);
        e_cerr  = cw && (!cs || !mapped(ca));
        e_rd    = model_rd(ca);
        checks++;
        if (acc_allow !== e_allow || acc_err !== e_err ||
            cfg_err !== e_cerr || cfg_rdata !== e_rd) begin
            errors++;
            $display("FAIL %s: addr=%h sup=%0b wr=%0b fe=%0b cfg=%h got allow/err/cerr/rd=%0b/%0b/%0b/%h exp %0b/%0b/%0b/%h",
                     req, a, sup, wr, fe, ca, acc_allow, acc_err, cfg_err, cfg_rdata,
                     e_allow, e_err, e_cerr, e_rd);
        end
        @(posedge clk);
        if (cw && cs) model_write(ca, wd);
    endtask

    task automatic cfg_write(logic [7:0] ad, logic [7:0] d, bit sup, string req);
        step(0, '0, 0, 0, 0, 1, ad, d, sup, req);
    endtask

    task automatic probe(logic [29:0] a, string req);
        for (int m = 0; m < 6; m++)
            step(1, a, m[0], m[1], m[2] & ~m[1], 0, 8'h30, 8'h00, 0, req);
    endtask

    function automatic logic [29:0] pick_addr(int s);
        case (s % 7)
            0: return 30'h0300_0000 | 30'($urandom % 'h1000);
            1: return 30'h0400_0000 | 30'($urandom % 'h100_0000);
            2: return {4'(2 + $urandom % 14), 26'($urandom)};
            3: return 30'(((1 + $urandom % 16) << 16) | ($urandom % 'h1_0000));
            4: return 30'h0011_0000;
            5: return 30'h0000_0040;
            default: return 30'h0010_FFFC;
        endcase
    endfunction

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R7 reset values and R8 read-back map
        for (int ad = 'h20; ad <= 'h34; ad++)
            step(0, '0, 0, 0, 0, 0, 8'(ad), 8'h00, 0, "R7");
        probe(30'h0300_0000, "R7");
        probe(30'h0001_0000, "R7");
        // R1 reserved regions
        for (int r = 2; r < 16; r++) probe({4'(r), 26'h0}, "R1");
        // R2 idle
        step(0, 30'h0300_0000, 1, 0, 0, 0, 8'h31, 8'h00, 0, "R2");

        // R3/R4 every region code, both regions
        for (int c = 0; c < 16; c++) begin
            cfg_write(8'h30, 8'(c), 1, "R3");
            cfg_write(8'h31, 8'(15 - c), 1, "R3");
            probe(30'h0300_0000, "R3");
            probe(30'h0000_0000, "R4");
            probe(30'h07FF_FFFC, "R4");
        end

        // R5/R6 module codes override region, nibble packing
        cfg_write(8'h30, 8'h0A, 1, "R5");
        for (int c = 0; c < 8; c++) begin
            cfg_write(8'h24, 8'((c << 4) | ((7 - c) & 7)), 1, "R6");
            cfg_write(8'h2B, 8'(((c + 2) % 8) << 4 | c), 1, "R8");
            probe(30'h0001_0000, "R5");
            probe(30'h0002_1234, "R6");
            probe(30'h0010_0008, "R8");
            probe(30'h0011_0000, "R5");
        end

        // R10 user and unmapped writes
        cfg_write(8'h30, 8'h02, 0, "R10");
        step(0, '0, 0, 0, 0, 0, 8'h30, 8'h00, 0, "R10");
        cfg_write(8'h32, 8'h8F, 1, "R10");
        cfg_write(8'h23, 8'h8F, 1, "R10");
        cfg_write(8'h26, 8'h33, 0, "R10");
        step(0, '0, 0, 0, 0, 0, 8'h26, 8'h00, 0, "R10");

        // R9 locks, R8 reserved bits
        cfg_write(8'h31, 8'hF1, 1, "R8");
        cfg_write(8'h30, 8'h82, 1, "R9");
        cfg_write(8'h30, 8'h00, 1, "R9");
        step(0, '0, 0, 0, 0, 0, 8'h30, 8'h00, 0, "R9");
        probe(30'h0300_0000, "R9");
        cfg_write(8'h25, 8'h83, 1, "R9");
        cfg_write(8'h25, 8'h05, 1, "R9");
        step(0, '0, 0, 0, 0, 0, 8'h25, 8'h00, 0, "R9");
        probe(30'h0005_0000, "R9");
        probe(30'h0006_0000, "R9");

        // randomized mix of accesses and configuration traffic
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 4) != 0, pick_addr($urandom % 7), $urandom % 2,
                 $urandom % 2, ($urandom % 4) == 0,
                 ($urandom % 5) == 0, 8'(8'h22 + $urandom % 18), 8'($urandom),
                 ($urandom % 4) != 0, "R2");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule